// File: doc/BRIEF.md
# Stacked Register Frame Remapper

This block turns logical register numbers into physical register indices for a 128-entry integer register file. The 32 lowest logical numbers are global. They always map to the same physical registers. The remaining 96 logical numbers form a stacked region. Each procedure sees its own window onto that region. The window is described by a base offset and a size, and it can move.

Three commands change the window, and each takes effect at a clock edge:
- **call** saves the caller's window on an internal 8-deep stack. The new window starts right after the caller's registers and is empty.
- **return** restores the saved window.
- **alloc** sets the size of the current window.

Two read ports and one write port are translated combinationally from the current window. Each port also reports when its register lies outside the current window. A call with the stack full is refused and reported, and so is a return with the stack empty.

Top module: `regframe_remap`

## Requirements
- R1: After reset, the window base is 0, the window size is 0, the saved-window stack is empty, and both the overflow and underflow flags are low.
- R2: A logical register below 32 maps to the physical register with the same number, and its out-of-window flag is low.
- R3: A logical register r of 32 or more maps to physical register 32 + ((base + r − 32) mod 96). The mapping uses the window in effect in that cycle, and each of the three ports is translated on its own.
- R4: A port's out-of-window flag is high exactly when its logical register r is 32 or more and r − 32 ≥ size.
- R5: An alloc sets the window size at the next clock edge. Requested sizes above 96 are stored as 96.
- R6: A call saves the current base and size, sets the base to (base + size) mod 96, and sets the size to 0, all at the next clock edge.
- R7: A return restores the most recently saved base and size, in last-in first-out order.
- R8: A return with no saved window leaves the base and size unchanged. The underflow flag is then high for exactly the cycle after that edge.
- R9: A call with 8 windows already saved leaves the base and size unchanged. The overflow flag is then high for exactly the cycle after that edge.
- R10: When several commands are asserted in the same cycle, only one takes effect, in this priority: call, then return, then alloc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Open a new window (procedure call) |
| ret_i | input | 1 | Restore the saved window (procedure return) |
| alloc_i | input | 1 | Set the current window size |
| alloc_size_i | input | 7 | Requested window size |
| rd0_lreg_i | input | 7 | Read port 0 logical register |
| rd1_lreg_i | input | 7 | Read port 1 logical register |
| wr_lreg_i | input | 7 | Write port logical register |
| rd0_preg_o | output | 7 | Read port 0 physical index |
| rd1_preg_o | output | 7 | Read port 1 physical index |
| wr_preg_o | output | 7 | Write port physical index |
| rd0_oof_o | output | 1 | Read port 0 register outside the window |
| rd1_oof_o | output | 1 | Read port 1 register outside the window |
| wr_oof_o | output | 1 | Write port register outside the window |
| overflow_o | output | 1 | Call refused because the stack is full |
| underflow_o | output | 1 | Return refused because the stack is empty |
| frame_base_o | output | 7 | Current window base (0 to 95) |
| frame_size_o | output | 7 | Current window size (0 to 96) |

## Verification
The bench nests calls until the base passes 96, so that a stacked register must wrap back into the region. A design that forgets the modulo would point such a register past 127 or into the global registers.

It fills all eight saved entries and then issues one more call, which must be refused. It drains the stack and issues one more return, which must also be refused. A design with an off-by-one in its occupancy count would corrupt the window, or raise a flag too early or too late.

It drives all three commands at once to check the priority order. It requests an oversized alloc to check saturation. It probes the registers at size − 1 and at size to catch a wrong boundary in the out-of-window compare.

// File: rtl/regframe_pkg.sv
package regframe_pkg;

  typedef enum logic [1:0] {
    FCMD_IDLE  = 2'd0,
    FCMD_CALL  = 2'd1,
    FCMD_RET   = 2'd2,
    FCMD_ALLOC = 2'd3
  } fcmd_e;

  function automatic fcmd_e pick_cmd(input logic call, input logic ret, input logic alloc);
    if (call)       return FCMD_CALL;
    else if (ret)   return FCMD_RET;
    else if (alloc) return FCMD_ALLOC;
    else            return FCMD_IDLE;
  endfunction

endpackage

// File: rtl/regframe_xlate.sv
module regframe_xlate #(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int NUM_STACKED = NUM_REGS - NUM_STATIC
) (
  input  logic [IDX_W-1:0] lreg_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] size_i,
  output logic [IDX_W-1:0] preg_o,
  output logic             oof_o
);
  logic             stacked;
  logic [IDX_W-1:0] offset;
  logic [IDX_W:0]   raw_sum;
  logic [IDX_W:0]   wrapped;

  always_comb begin
    stacked = (lreg_i >= IDX_W'(NUM_STATIC));
    offset  = lreg_i - IDX_W'(NUM_STATIC);
    raw_sum = {1'b0, base_i} + {1'b0, offset};
    if (raw_sum >= (IDX_W+1)'(NUM_STACKED))
      wrapped = raw_sum - (IDX_W+1)'(NUM_STACKED);
    else
      wrapped = raw_sum;
    preg_o = stacked ? (wrapped[IDX_W-1:0] + IDX_W'(NUM_STATIC)) : lreg_i;
    oof_o  = stacked && (offset >= size_i);
  end
endmodule

// File: rtl/regframe_stack.sv
module regframe_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 14,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] top_data_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [PTR_W-1:0]  wr_ptr, top_ptr;

  always_comb begin
    full_o  = (cnt_q == CNT_W'(DEPTH));
    empty_o = (cnt_q == '0);
    wr_ptr  = cnt_q[PTR_W-1:0];
    top_ptr = PTR_W'(cnt_q - CNT_W'(1));
    cnt_en  = push_i | pop_i;
    cnt_d   = cnt_q;
    if (push_i)     cnt_d = cnt_q + CNT_W'(1);
    else if (pop_i) cnt_d = cnt_q - CNT_W'(1);
  end

  assign top_data_o = slot_q[top_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_i && (wr_ptr == PTR_W'(g))) slot_q[g] <= push_data_i;
      end
    end
  endgenerate
endmodule

// File: rtl/regframe_ctrl.sv
module regframe_ctrl
  import regframe_pkg::*;
#(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int NUM_STACKED = NUM_REGS - NUM_STATIC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic               alloc_i,
  input  logic [IDX_W-1:0]   alloc_size_i,
  input  logic [2*IDX_W-1:0] top_frame_i,
  input  logic               full_i,
  input  logic               empty_i,
  output logic               push_o,
  output logic               pop_o,
  output logic [2*IDX_W-1:0] push_frame_o,
  output logic [IDX_W-1:0]   base_o,
  output logic [IDX_W-1:0]   size_o,
  output logic               overflow_o,
  output logic               underflow_o
);
  fcmd_e            cmd;
  logic [IDX_W-1:0] base_q, base_d, size_q, size_d;
  logic             frame_en;
  logic             ovf_d, unf_d, ovf_q, unf_q;
  logic [IDX_W:0]   adv_sum;

  always_comb begin
    cmd          = pick_cmd(call_i, ret_i, alloc_i);
    base_d       = base_q;
    size_d       = size_q;
    push_o       = 1'b0;
    pop_o        = 1'b0;
    ovf_d        = 1'b0;
    unf_d        = 1'b0;
    push_frame_o = {base_q, size_q};
    adv_sum      = {1'b0, base_q} + {1'b0, size_q};
    if (adv_sum >= (IDX_W+1)'(NUM_STACKED))
      adv_sum = adv_sum - (IDX_W+1)'(NUM_STACKED);
    unique case (cmd)
      FCMD_CALL: begin
        if (full_i) ovf_d = 1'b1;
        else begin
          push_o = 1'b1;
          base_d = adv_sum[IDX_W-1:0];
          size_d = '0;
        end
      end
      FCMD_RET: begin
        if (empty_i) unf_d = 1'b1;
        else begin
          pop_o  = 1'b1;
          base_d = top_frame_i[2*IDX_W-1:IDX_W];
          size_d = top_frame_i[IDX_W-1:0];
        end
      end
      FCMD_ALLOC: begin
        if (alloc_size_i > IDX_W'(NUM_STACKED)) size_d = IDX_W'(NUM_STACKED);
        else                                    size_d = alloc_size_i;
      end
      default: ;
    endcase
    frame_en = push_o | pop_o | (cmd == FCMD_ALLOC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (frame_en) begin
      base_q <= base_d;
      size_q <= size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign base_o      = base_q;
  assign size_o      = size_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/regframe_remap.sv
module regframe_remap #(
  parameter int NUM_REGS    = 128,
  parameter int NUM_STATIC  = 32,
  parameter int SAVE_DEPTH  = 8,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int NUM_PORTS  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_size_i,
  input  logic [IDX_W-1:0] rd0_lreg_i,
  input  logic [IDX_W-1:0] rd1_lreg_i,
  input  logic [IDX_W-1:0] wr_lreg_i,
  output logic [IDX_W-1:0] rd0_preg_o,
  output logic [IDX_W-1:0] rd1_preg_o,
  output logic [IDX_W-1:0] wr_preg_o,
  output logic             rd0_oof_o,
  output logic             rd1_oof_o,
  output logic             wr_oof_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic [IDX_W-1:0] frame_base_o,
  output logic [IDX_W-1:0] frame_size_o
);
  logic [2*IDX_W-1:0] push_frame, top_frame;
  logic               push, pop, full, empty;
  logic [IDX_W-1:0]   base, size;
  logic [IDX_W-1:0]   lreg_arr [NUM_PORTS];
  logic [IDX_W-1:0]   preg_arr [NUM_PORTS];
  logic               oof_arr  [NUM_PORTS];

  regframe_ctrl #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) u_ctrl (
    .clk, .rst_n, .call_i, .ret_i, .alloc_i, .alloc_size_i,
    .top_frame_i(top_frame), .full_i(full), .empty_i(empty),
    .push_o(push), .pop_o(pop), .push_frame_o(push_frame),
    .base_o(base), .size_o(size),
    .overflow_o, .underflow_o
  );

  regframe_stack #(.DEPTH(SAVE_DEPTH), .DATA_W(2*IDX_W)) u_stack (
    .clk, .rst_n, .push_i(push), .pop_i(pop), .push_data_i(push_frame),
    .top_data_o(top_frame), .full_o(full), .empty_o(empty)
  );

  assign lreg_arr[0] = rd0_lreg_i;
  assign lreg_arr[1] = rd1_lreg_i;
  assign lreg_arr[2] = wr_lreg_i;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      regframe_xlate #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) u_xl (
        .lreg_i(lreg_arr[p]), .base_i(base), .size_i(size),
        .preg_o(preg_arr[p]), .oof_o(oof_arr[p])
      );
    end
  endgenerate

  assign rd0_preg_o   = preg_arr[0];
  assign rd1_preg_o   = preg_arr[1];
  assign wr_preg_o    = preg_arr[2];
  assign rd0_oof_o    = oof_arr[0];
  assign rd1_oof_o    = oof_arr[1];
  assign wr_oof_o     = oof_arr[2];
  assign frame_base_o = base;
  assign frame_size_o = size;
endmodule

// File: rtl/regframe_chk.sv
module regframe_chk #(
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int NUM_STACKED = NUM_REGS - NUM_STATIC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_i,
  input logic             ret_i,
  input logic             alloc_i,
  input logic [IDX_W-1:0] alloc_size_i,
  input logic [IDX_W-1:0] rd0_lreg_i,
  input logic [IDX_W-1:0] rd1_lreg_i,
  input logic [IDX_W-1:0] wr_lreg_i,
  input logic [IDX_W-1:0] rd0_preg_o,
  input logic [IDX_W-1:0] rd1_preg_o,
  input logic [IDX_W-1:0] wr_preg_o,
  input logic             rd0_oof_o,
  input logic             rd1_oof_o,
  input logic             wr_oof_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic [IDX_W-1:0] frame_base_o,
  input logic [IDX_W-1:0] frame_size_o
);
  a_r2_static_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_lreg_i < IDX_W'(NUM_STATIC)) |-> (rd0_preg_o == rd0_lreg_i && !rd0_oof_o));

  a_r3_stacked_stays_stacked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lreg_i >= IDX_W'(NUM_STATIC)) |-> (wr_preg_o >= IDX_W'(NUM_STATIC)));

  a_r4_oof_only_stacked: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_oof_o |-> (rd1_lreg_i >= IDX_W'(NUM_STATIC)));

  a_r5_size_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_size_o <= IDX_W'(NUM_STACKED)) && (frame_base_o < IDX_W'(NUM_STACKED)));

  a_r6_call_empties_window: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> (overflow_o || frame_size_o == '0));

  a_r8_underflow_holds_frame: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> ($stable(frame_base_o) && $stable(frame_size_o)));

  a_r9_overflow_holds_frame: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> ($stable(frame_base_o) && $stable(frame_size_o)));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_o && underflow_o));
endmodule

bind regframe_remap regframe_chk #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) u_chk (.*);

// File: tb/tb_regframe_remap.sv
module tb_regframe_remap;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 128, NST = 32, NSK = 96, DEPTH = 8;

  logic       clk, rst_n, call_i, ret_i, alloc_i;
  logic [6:0] alloc_size_i, rd0_lreg_i, rd1_lreg_i, wr_lreg_i;
  logic [6:0] rd0_preg_o, rd1_preg_o, wr_preg_o, frame_base_o, frame_size_o;
  logic       rd0_oof_o, rd1_oof_o, wr_oof_o, overflow_o, underflow_o;

  regframe_remap dut (.*);

  typedef struct {
    int    l [3];
    int    p [3];
    bit    o [3];
    bit    ovf, unf;
    int    base, size;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  bit   done = 0;

  int m_base = 0, m_size = 0, m_depth = 0;
  int s_base [DEPTH];
  int s_size [DEPTH];
  bit pend_ovf = 0, pend_unf = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int xl(input int l, input int b);
    if (l < NST) return l;
    return NST + ((b + l - NST) % NSK);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: drives one cycle of stimulus and queues the expected sample
  task automatic step(input bit c, input bit r, input bit a, input int asz,
                      input int l0, input int l1, input int lw, input string tag);
    exp_t e;
    @(negedge clk);
    call_i = c; ret_i = r; alloc_i = a; alloc_size_i = 7'(asz);
    rd0_lreg_i = 7'(l0); rd1_lreg_i = 7'(l1); wr_lreg_i = 7'(lw);
    e.l[0] = l0; e.l[1] = l1; e.l[2] = lw;
    for (int i = 0; i < 3; i++) begin
      e.p[i] = xl(e.l[i], m_base);
      e.o[i] = (e.l[i] >= NST) && ((e.l[i] - NST) >= m_size);
    end
    e.ovf = pend_ovf; e.unf = pend_unf;
    e.base = m_base; e.size = m_size; e.tag = tag;
    exp_q.push_back(e);
    pend_ovf = 0; pend_unf = 0;
    if (c) begin
      if (m_depth == DEPTH) pend_ovf = 1;
      else begin
        s_base[m_depth] = m_base; s_size[m_depth] = m_size; m_depth++;
        m_base = (m_base + m_size) % NSK; m_size = 0;
      end
    end else if (r) begin
      if (m_depth == 0) pend_unf = 1;
      else begin
        m_depth--; m_base = s_base[m_depth]; m_size = s_size[m_depth];
      end
    end else if (a) begin
      m_size = (asz > NSK) ? NSK : asz;
    end
  endtask

  // monitor: compares each queued expectation just after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk((e.l[0] < NST) ? "R2" : "R3", "rd0_preg", int'(rd0_preg_o), e.p[0]);
        chk((e.l[1] < NST) ? "R2" : "R3", "rd1_preg", int'(rd1_preg_o), e.p[1]);
        chk((e.l[2] < NST) ? "R2" : "R3", "wr_preg",  int'(wr_preg_o),  e.p[2]);
        chk("R4", "rd0_oof", int'(rd0_oof_o), int'(e.o[0]));
        chk("R4", "rd1_oof", int'(rd1_oof_o), int'(e.o[1]));
        chk("R4", "wr_oof",  int'(wr_oof_o),  int'(e.o[2]));
        chk(e.tag, "frame_base", int'(frame_base_o), e.base);
        chk(e.tag, "frame_size", int'(frame_size_o), e.size);
        chk(e.tag, "overflow",  int'(overflow_o),  int'(e.ovf));
        chk(e.tag, "underflow", int'(underflow_o), int'(e.unf));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    call_i = 0; ret_i = 0; alloc_i = 0; alloc_size_i = 0;
    rd0_lreg_i = 0; rd1_lreg_i = 0; wr_lreg_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R2 static registers
    step(0,0,0,0,   0, 31, 5,   "R1");
    step(0,0,1,10,  32, 45, 127, "R1");
    // R5 alloc, R4 boundary at size-1 and size
    step(0,0,0,0,   32, 41, 42,  "R5");
    step(0,0,1,100, 33, 1, 2,    "R5");
    step(0,0,1,10,  127, 96, 32, "R5");   // saturated to 96
    // R6 call advances base
    step(1,0,0,0,   41, 42, 0,   "R5");
    step(0,0,1,20,  32, 51, 52,  "R6");
    step(1,0,0,0,   32, 51, 52,  "R5");
    step(0,0,1,90,  32, 40, 127, "R6");
    step(1,0,0,0,   112, 121, 122, "R5");
    // wrap of base past the stacked region
    step(0,0,1,96,  112, 32, 127, "R6");
    step(0,0,0,0,   112, 32, 127, "R3");
    // fill the save stack (3 saved so far), then overflow R9
    for (int k = 0; k < 5; k++) step(1,0,0,0, 33, 64, 100, "R6");
    step(1,0,1,3,   40, 50, 60,  "R6");
    step(0,0,0,0,   40, 50, 60,  "R9");
    // drain the stack R7, then underflow R8
    for (int k = 0; k < DEPTH; k++) step(0,1,0,0, 32, 70, 127, "R7");
    step(0,1,1,9,   32, 70, 127, "R7");
    step(0,0,0,0,   32, 70, 127, "R8");
    // R10 priority: call beats return and alloc, return beats alloc
    step(1,1,1,5,   50, 60, 10,  "R8");
    step(0,1,1,7,   50, 60, 10,  "R10");
    step(0,0,0,0,   50, 60, 10,  "R10");
    step(0,0,1,0,   32, 33, 31,  "R10");
    step(0,0,0,0,   32, 33, 31,  "R5");
    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule